// File: doc/BRIEF.md
# Receive Destination Address Channel Classifier

This block decides, for every incoming frame, which of eight receive queues gets it, or whether it is dropped. It looks only at the 48-bit destination address, a valid strobe and an error flag. These arrive once per frame, after an earlier stage has pulled them out of the frame header.

Each channel owns a programmable unicast address with its own enable, so the receive path can act as eight separate network adapters on one port. Broadcast, multicast and promiscuous traffic each have an enable and a target channel of their own. Errored frames can be sent to the promiscuous channel. The verdict is an accept flag and a channel number, registered, with a result strobe one clock after the input strobe.

Top module: `rx_dest_classifier`

## Requirements
- R1: `result_valid_o` is high in exactly the cycle after each cycle in which `frame_valid_i` is sampled high, including back-to-back frames. When `result_valid_o` is low, `accept_o` and `chan_o` are 0.
- R2: If an error-free frame's destination equals the address of an enabled channel k, it is accepted on channel k. Channel k's address is `uc_addr_i[48*k+47 : 48*k]` and its enable is `uc_en_i[k]`.
- R3: When several enabled unicast entries match, the lowest-numbered channel wins.
- R4: An entry whose enable bit is 0 never matches, even if its address is equal.
- R5: An error-free all-ones destination that matched no unicast entry goes to `bcast_chan_i` when `bcast_en_i` is 1.
- R6: An error-free destination with bit 40 set, which is the group bit of the first octet held in bits 47:40, and that is not all ones, goes to `mcast_chan_i` when `mcast_en_i` is 1 and no unicast entry matched.
- R7: An error-free frame that is not claimed by R2, R5 or R6 goes to `promisc_chan_i` when `promisc_en_i` is 1. This includes a broadcast with broadcast disabled and a multicast with multicast disabled.
- R8: An error-free frame that matches nothing enabled gives `accept_o` = 0 and `chan_o` = 0.
- R9: A frame with `frame_err_i` set ignores its address. It goes to `promisc_chan_i` if `err_en_i` is 1 and is rejected otherwise.
- R10: During and after reset, with no frame in progress, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Destination address strobe, one cycle per frame |
| dest_addr_i | input | 48 | Destination address, first octet in bits 47:40 |
| frame_err_i | input | 1 | Frame carries an error |
| uc_addr_i | input | 384 | Per-channel unicast addresses, 48 bits per channel |
| uc_en_i | input | 8 | Per-channel unicast enables |
| bcast_en_i | input | 1 | Broadcast acceptance enable |
| bcast_chan_i | input | 3 | Broadcast target channel |
| mcast_en_i | input | 1 | Multicast acceptance enable |
| mcast_chan_i | input | 3 | Multicast target channel |
| promisc_en_i | input | 1 | Promiscuous acceptance enable |
| promisc_chan_i | input | 3 | Promiscuous and error-frame target channel |
| err_en_i | input | 1 | Error-frame acceptance enable |
| result_valid_o | output | 1 | Verdict strobe, one cycle after frame_valid_i |
| accept_o | output | 1 | Frame accepted |
| chan_o | output | 3 | Selected receive channel |

## Verification
The assertions compare a verdict with the configuration inputs one cycle earlier, using `$past`. They therefore assume the configuration stays steady from the strobe to the result. The bench changes configuration only when no frame is in flight, one idle cycle away from any strobe. The assertions also assume `frame_err_i` and `dest_addr_i` are meaningful only while the strobe is high. The bench drives them together with the strobe and clears the strobe after each frame, except in the back-to-back test, where every cycle carries a full, valid frame.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int unsigned MAC_W = 48;
  localparam int unsigned GROUP_BIT = 40;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_UCAST,
    CLS_BCAST,
    CLS_MCAST,
    CLS_PROMISC,
    CLS_ERROR
  } rx_class_e;
endpackage

// File: rtl/rxc_uc_match.sv
module rxc_uc_match
  import rxc_pkg::*;
#(
  parameter int unsigned N_CHAN = 8
) (
  input  logic [MAC_W-1:0]        dest_i,
  input  logic [N_CHAN*MAC_W-1:0] uc_addr_i,
  input  logic [N_CHAN-1:0]       uc_en_i,
  output logic [N_CHAN-1:0]       hit_o
);
  for (genvar k = 0; k < N_CHAN; k++) begin : g_cmp
    assign hit_o[k] = uc_en_i[k] && (uc_addr_i[k*MAC_W +: MAC_W] == dest_i);
  end
endmodule

// File: rtl/rxc_prio_pick.sv
module rxc_prio_pick #(
  parameter int unsigned N_CHAN = 8,
  localparam int unsigned CH_W = $clog2(N_CHAN)
) (
  input  logic [N_CHAN-1:0] hit_i,
  output logic              any_o,
  output logic [CH_W-1:0]   idx_o
);
  // lowest index wins: scan from top so the last write is the lowest
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_CHAN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = CH_W'(i);
      end
    end
  end

  // R3
  always_comb begin
    lowest_hit_chk: assert (!any_o || (hit_i[idx_o] && ((hit_i & ((N_CHAN'(1) << idx_o) - N_CHAN'(1))) == '0)));
  end
endmodule

// File: rtl/rxc_decide.sv
module rxc_decide
  import rxc_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input  logic [MAC_W-1:0] dest_i,
  input  logic             err_i,
  input  logic             uc_any_i,
  input  logic [CH_W-1:0]  uc_idx_i,
  input  logic             bcast_en_i,
  input  logic [CH_W-1:0]  bcast_chan_i,
  input  logic             mcast_en_i,
  input  logic [CH_W-1:0]  mcast_chan_i,
  input  logic             promisc_en_i,
  input  logic [CH_W-1:0]  promisc_chan_i,
  input  logic             err_en_i,
  output logic             accept_o,
  output logic [CH_W-1:0]  chan_o
);
  rx_class_e cls;
  logic is_bcast, is_mcast;

  assign is_bcast = &dest_i;
  assign is_mcast = dest_i[GROUP_BIT] && !is_bcast;

  always_comb begin
    cls = CLS_NONE;
    if (err_i) begin
      if (err_en_i) cls = CLS_ERROR;
    end else if (uc_any_i)                cls = CLS_UCAST;
    else if (is_bcast && bcast_en_i)      cls = CLS_BCAST;
    else if (is_mcast && mcast_en_i)      cls = CLS_MCAST;
    else if (promisc_en_i)                cls = CLS_PROMISC;
  end

  always_comb begin
    accept_o = (cls != CLS_NONE);
    unique case (cls)
      CLS_UCAST:               chan_o = uc_idx_i;
      CLS_BCAST:               chan_o = bcast_chan_i;
      CLS_MCAST:               chan_o = mcast_chan_i;
      CLS_PROMISC, CLS_ERROR:  chan_o = promisc_chan_i;
      default:                 chan_o = '0;
    endcase
  end
endmodule

// File: rtl/rx_dest_classifier.sv
module rx_dest_classifier
  import rxc_pkg::*;
#(
  parameter int unsigned N_CHAN = 8,
  localparam int unsigned CH_W = $clog2(N_CHAN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_valid_i,
  input  logic [MAC_W-1:0]        dest_addr_i,
  input  logic                    frame_err_i,
  input  logic [N_CHAN*MAC_W-1:0] uc_addr_i,
  input  logic [N_CHAN-1:0]       uc_en_i,
  input  logic                    bcast_en_i,
  input  logic [CH_W-1:0]         bcast_chan_i,
  input  logic                    mcast_en_i,
  input  logic [CH_W-1:0]         mcast_chan_i,
  input  logic                    promisc_en_i,
  input  logic [CH_W-1:0]         promisc_chan_i,
  input  logic                    err_en_i,
  output logic                    result_valid_o,
  output logic                    accept_o,
  output logic [CH_W-1:0]         chan_o
);
  logic [N_CHAN-1:0] uc_hit;
  logic              uc_any;
  logic [CH_W-1:0]   uc_idx;
  logic              acc_d;
  logic [CH_W-1:0]   chan_d;

  rxc_uc_match #(.N_CHAN(N_CHAN)) i_match (
    .dest_i    (dest_addr_i),
    .uc_addr_i (uc_addr_i),
    .uc_en_i   (uc_en_i),
    .hit_o     (uc_hit)
  );

  rxc_prio_pick #(.N_CHAN(N_CHAN)) i_pick (
    .hit_i (uc_hit),
    .any_o (uc_any),
    .idx_o (uc_idx)
  );

  rxc_decide #(.CH_W(CH_W)) i_decide (
    .dest_i         (dest_addr_i),
    .err_i          (frame_err_i),
    .uc_any_i       (uc_any),
    .uc_idx_i       (uc_idx),
    .bcast_en_i     (bcast_en_i),
    .bcast_chan_i   (bcast_chan_i),
    .mcast_en_i     (mcast_en_i),
    .mcast_chan_i   (mcast_chan_i),
    .promisc_en_i   (promisc_en_i),
    .promisc_chan_i (promisc_chan_i),
    .err_en_i       (err_en_i),
    .accept_o       (acc_d),
    .chan_o         (chan_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_valid_o <= 1'b0;
      accept_o       <= 1'b0;
      chan_o         <= '0;
    end else begin
      result_valid_o <= frame_valid_i;
      accept_o       <= frame_valid_i && acc_d;
      chan_o         <= (frame_valid_i && acc_d) ? chan_d : '0;
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> result_valid_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> (!result_valid_o && !accept_o && chan_o == '0));
  // R9
  err_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && frame_err_i && !err_en_i) |=> !accept_o);
  // R9
  err_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && frame_err_i && err_en_i) |=> (accept_o && chan_o == $past(promisc_chan_i)));
  // R2
  uc_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !frame_err_i && uc_any) |=> (accept_o && chan_o == $past(uc_idx)));
  // R5
  bcast_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !frame_err_i && !uc_any && (&dest_addr_i) && bcast_en_i)
      |=> (accept_o && chan_o == $past(bcast_chan_i)));
endmodule

// File: tb/test_rx_dest_classifier.sv
module test_rx_dest_classifier;
  localparam int unsigned N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_valid = 1'b0;
  logic [47:0] dest = '0;
  logic frame_err = 1'b0;
  logic [N*48-1:0] uc_addr;
  logic [N-1:0] uc_en;
  logic bc_en, mc_en, pr_en, er_en;
  logic [2:0] bc_ch, mc_ch, pr_ch;
  logic res_v, acc;
  logic [2:0] ch;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_dest_classifier i_rx_dest_classifier (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(frame_valid), .dest_addr_i(dest),
    .frame_err_i(frame_err), .uc_addr_i(uc_addr), .uc_en_i(uc_en),
    .bcast_en_i(bc_en), .bcast_chan_i(bc_ch), .mcast_en_i(mc_en), .mcast_chan_i(mc_ch),
    .promisc_en_i(pr_en), .promisc_chan_i(pr_ch), .err_en_i(er_en),
    .result_valid_o(res_v), .accept_o(acc), .chan_o(ch)
  );

  typedef struct packed {
    logic [47:0] addr;
    logic        err;
    logic        exp_acc;
    logic [2:0]  exp_ch;
  } vec_t;

  // config: ch k = 0x020000000010+k, ch5 duplicates ch2, ch6 disabled,
  // bcast->7, mcast->4, promisc off (->1), error acceptance off
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{48'h020000000010, 1'b0, 1'b1, 3'd0},  // R2
    '{48'h020000000013, 1'b0, 1'b1, 3'd3},  // R2
    '{48'h020000000017, 1'b0, 1'b1, 3'd7},  // R2
    '{48'h020000000012, 1'b0, 1'b1, 3'd2},  // R3 ch2 and ch5 both match
    '{48'h020000000016, 1'b0, 1'b0, 3'd0},  // R4 ch6 disabled
    '{48'hffffffffffff, 1'b0, 1'b1, 3'd7},  // R5
    '{48'h01005e000001, 1'b0, 1'b1, 3'd4},  // R6
    '{48'h020000000099, 1'b0, 1'b0, 3'd0},  // R8
    '{48'h020000000010, 1'b1, 1'b0, 3'd0},  // R9 error, acceptance off
    '{48'h030000000000, 1'b0, 1'b1, 3'd4}   // R6 group bit only
  };

  task automatic check(input string req, input logic a_acc, input logic [2:0] a_ch,
                       input logic e_acc, input logic [2:0] e_ch);
    n_chk++;
    if (a_acc !== e_acc || a_ch !== e_ch) begin
      n_fail++;
      $display("FAIL %s: accept=%0b chan=%0d, expected accept=%0b chan=%0d", req, a_acc, a_ch, e_acc, e_ch);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // one frame, verdict checked one clock after the strobe
  task automatic send(input string req, input logic [47:0] a, input logic e,
                      input logic e_acc, input logic [2:0] e_ch);
    @(negedge clk);
    frame_valid = 1'b1; dest = a; frame_err = e;
    @(negedge clk);
    frame_valid = 1'b0; dest = '0; frame_err = 1'b0;
    check_bit(req, res_v, 1'b1);
    check(req, acc, ch, e_acc, e_ch);
    @(negedge clk);
    check_bit("R1 strobe drops", res_v, 1'b0);
  endtask

  initial begin
    for (int k = 0; k < N; k++) uc_addr[k*48 +: 48] = 48'h020000000010 + 48'(k);
    uc_addr[5*48 +: 48] = 48'h020000000012;
    uc_en = 8'b1011_1111;
    bc_en = 1'b1; bc_ch = 3'd7;
    mc_en = 1'b1; mc_ch = 3'd4;
    pr_en = 1'b0; pr_ch = 3'd1;
    er_en = 1'b0;

    repeat (3) @(negedge clk);
    check_bit("R10 reset valid", res_v, 1'b0);
    check("R10 reset outputs", acc, ch, 1'b0, 3'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 idle after reset", acc, ch, 1'b0, 3'd0);

    for (int i = 0; i < NV; i++)
      send($sformatf("vector %0d", i), VEC[i].addr, VEC[i].err, VEC[i].exp_acc, VEC[i].exp_ch);

    // R7 promiscuous catches leftovers
    pr_en = 1'b1;
    send("R7 unmatched", 48'h020000000099, 1'b0, 1'b1, 3'd1);
    send("R7 disabled entry", 48'h020000000016, 1'b0, 1'b1, 3'd1);
    bc_en = 1'b0;
    send("R7 bcast disabled", 48'hffffffffffff, 1'b0, 1'b1, 3'd1);
    mc_en = 1'b0;
    send("R7 mcast disabled", 48'h01005e000001, 1'b0, 1'b1, 3'd1);
    send("R2 unicast beats promisc", 48'h020000000014, 1'b0, 1'b1, 3'd4);

    // R9 error frames
    er_en = 1'b1;
    send("R9 error accepted", 48'h020000000013, 1'b1, 1'b1, 3'd1);
    pr_en = 1'b0;
    send("R9 error without promisc", 48'hffffffffffff, 1'b1, 1'b1, 3'd1);
    er_en = 1'b0;
    send("R9 error rejected", 48'h020000000013, 1'b1, 1'b0, 3'd0);
    send("R8 mcast nothing enabled", 48'h01005e000001, 1'b0, 1'b0, 3'd0);

    // R3 with lower entry disabled, upper duplicate wins
    uc_en[2] = 1'b0;
    send("R3 R4 fallthrough to ch5", 48'h020000000012, 1'b0, 1'b1, 3'd5);
    uc_en[2] = 1'b1;

    // R1 back-to-back frames
    @(negedge clk);
    frame_valid = 1'b1; dest = 48'h020000000011;
    @(negedge clk);
    dest = 48'h020000000017;
    check_bit("R1 b2b first", res_v, 1'b1);
    check("R1 b2b first", acc, ch, 1'b1, 3'd1);
    @(negedge clk);
    frame_valid = 1'b0; dest = '0;
    check_bit("R1 b2b second", res_v, 1'b1);
    check("R1 b2b second", acc, ch, 1'b1, 3'd7);
    @(negedge clk);
    check_bit("R1 b2b end", res_v, 1'b0);
    check("R1 quiet outputs", acc, ch, 1'b0, 3'd0);

    // R10 reset mid-stream
    @(negedge clk);
    frame_valid = 1'b1; dest = 48'h020000000010;
    @(negedge clk);
    frame_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R10 async reset", acc, ch, 1'b0, 3'd0);
    check_bit("R10 async reset valid", res_v, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule